// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block merges interrupt requests from a raster-line source and three sound DMA channels into a single active-low interrupt line to the CPU. Each source owns a flag in a byte-wide control/status register. A flag reads 0 while its source is waiting for service, so the interrupt line is simply the AND of all flag bits. The same register also holds the three channel-enable bits. Any channel can clear its own enable bit through a stop input.

When the CPU acknowledges an interrupt, the block returns an 8-bit vector. The top five bits come from a programmable vector base register, and bits 2..1 encode the highest-priority pending source. The vector is latched on the acknowledge strobe. A raster flag is always retired by the acknowledge. A DMA flag is retired only when the auto-clear bit (bit 0 of the vector base register) is set; otherwise software clears it by writing 1 to it.

The acknowledge logic is a two-state machine:
- `ACK_WAIT` waits for a strobe. The transition to `ACK_HOLD` happens when `ack` is seen high; this takes the grant, latches the vector and issues the clear.
- `ACK_HOLD` lasts while `ack` stays high. The transition back to `ACK_WAIT` happens when `ack` goes low.

So each strobe is served exactly once, however long it lasts.

Register select: `reg_sel` = 0 addresses the control/status register, and `reg_sel` = 1 addresses the vector base register.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the control/status register reads 0xF0 (all flags idle, all enables 0), the vector base register reads 0x01, and `irq_n` is 1.
- R2: A write to the control/status register loads bits 2..0 into the enables of DMA channels 2..0, setting or clearing them. They read back on the same bits, and bit 3 reads 0.
- R3: A pulse on `dma_stop[k]` clears enable k by the next cycle. It wins over a CPU write that sets that bit in the same cycle.
- R4: A request pulse sets a flag to 0 in the next cycle: raster at bit 7, and DMA channels 2, 1, 0 at bits 6, 5, 4. `irq_n` is 0 whenever any flag is 0 and 1 when all flags are 1.
- R5: Writing 1 to bit 6, 5 or 4 of the control/status register returns that DMA flag to 1. Writing 0 to one of these bits leaves the flag unchanged. Writing 1 to bit 7 does not clear the raster flag.
- R6: Priority is fixed: raster, then DMA 2, then DMA 1, then DMA 0. Vector bits 2..1 are 11 for raster, 00 for DMA 2, 01 for DMA 1 and 10 for DMA 0.
- R7: Vector bits 7..3 equal bits 7..3 of the vector base register, and vector bit 0 is 0. Vector base bits 2..1 read as 0.
- R8: An acknowledge that serves the raster source always returns the raster flag to 1.
- R9: With vector base bit 0 = 1, an acknowledge that serves a DMA source returns its flag to 1. With bit 0 = 0, the flag stays 0 and the next acknowledge returns the same vector.
- R10: An acknowledge with no pending source returns the raster code (11) and changes no flag or enable.
- R11: The vector is latched at the first clock edge that sees `ack` high. It stays stable while `ack` is held, even when new requests arrive, and a held strobe retires at most one source.
- R12: A request arriving in the same cycle as a CPU clear or an acknowledge clear of the same flag leaves the flag pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control/status register, 1 = vector base register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| raster_req | input | 1 | Raster interrupt request pulse |
| dma_req | input | 3 | DMA channel interrupt request pulses, bit k = channel k |
| dma_stop | input | 3 | Stop-command pulses, bit k clears enable k |
| ack | input | 1 | Interrupt-acknowledge strobe |
| vector | output | 8 | Latched interrupt vector |
| irq_n | output | 1 | Active-low interrupt to the CPU |
| dma_en | output | 3 | Channel enable bits |

## Verification
Flags, enables and the vector are registered:
- A request, stop or register write shows at the ports one clock edge after it is driven.
- `irq_n` follows the flags with no further delay.
- The vector is due at the edge that first sees `ack` high.

The bench drives inputs just after a rising edge. The bench samples direct checks after the next edge. A monitor compares the queued expected vector at the falling edge that follows the acknowledge edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NUM_DMA   = 3;
    localparam int NUM_SRC   = NUM_DMA + 1;
    localparam int RASTER_IX = NUM_DMA;
    localparam int CODE_W    = 2;
    localparam int DATA_W    = 8;
    localparam int BASE_W    = DATA_W - CODE_W - 1;
    localparam logic [CODE_W-1:0] CODE_RASTER = 2'b11;

    typedef enum logic {ACK_WAIT, ACK_HOLD} ack_state_t;

    function automatic logic [CODE_W-1:0] dma_code(input int k);
        return CODE_W'(NUM_DMA - 1 - k);
    endfunction
endpackage

// File: rtl/irqv_flags.sv
module irqv_flags
    import irqv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raster_set,
    input  logic [NUM_DMA-1:0] dma_set,
    input  logic [NUM_DMA-1:0] cpu_clr,
    input  logic [NUM_SRC-1:0] ack_clr,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;

    always_comb begin
        set_v = {raster_set, dma_set};
        clr_v = ack_clr | {1'b0, cpu_clr};
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)         pend[i] <= 1'b0;
            else if (set_v[i])  pend[i] <= 1'b1;
            else if (clr_v[i])  pend[i] <= 1'b0;
        end

        // R12: a request always wins over a same-cycle clear
        a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> pend[i]);
    end

    // R8: raster flag retires on its acknowledge
    a_r8_raster_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr[RASTER_IX] && !raster_set) |=> !pend[RASTER_IX]);
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [NUM_DMA-1:0] dma_stop,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_DMA-1:0] en,
    output logic [NUM_DMA-1:0] cpu_clr,
    output logic [BASE_W-1:0]  vbase_hi,
    output logic               auto_clr,
    output logic [DATA_W-1:0]  reg_rdata
);
    localparam int GAP_W = DATA_W - NUM_SRC - NUM_DMA;

    logic csr_wr;
    logic vb_wr;

    always_comb begin
        csr_wr  = reg_wr && !reg_sel;
        vb_wr   = reg_wr && reg_sel;
        cpu_clr = csr_wr ? reg_wdata[NUM_SRC+GAP_W+NUM_DMA-2 -: NUM_DMA] : '0;
    end

    for (genvar k = 0; k < NUM_DMA; k++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n)           en[k] <= 1'b0;
            else if (dma_stop[k]) en[k] <= 1'b0;
            else if (csr_wr)      en[k] <= reg_wdata[k];
        end

        // R3: stop clears the matching enable
        a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
            dma_stop[k] |=> !en[k]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbase_hi <= '0;
            auto_clr <= 1'b1;
        end else if (vb_wr) begin
            vbase_hi <= reg_wdata[DATA_W-1 -: BASE_W];
            auto_clr <= reg_wdata[0];
        end
    end

    always_comb begin
        if (reg_sel) reg_rdata = {vbase_hi, {CODE_W{1'b0}}, auto_clr};
        else         reg_rdata = {~pend, {GAP_W{1'b0}}, en};
    end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] grant,
    output logic [CODE_W-1:0]  code
);
    always_comb begin
        grant = '0;
        code  = CODE_RASTER;
        if (pend[RASTER_IX]) begin
            grant[RASTER_IX] = 1'b1;
        end else begin
            for (int k = 0; k < NUM_DMA; k++) begin
                if (pend[k]) begin
                    grant    = '0;
                    grant[k] = 1'b1;
                    code     = dma_code(k);
                end
            end
        end
    end

    // R6: at most one source granted
    always_comb begin
        a_r6_onehot: assert ($onehot0(grant));
    end
endmodule

// File: rtl/irqv_ack_fsm.sv
module irqv_ack_fsm
    import irqv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] grant,
    input  logic [CODE_W-1:0]  code,
    input  logic [BASE_W-1:0]  vbase_hi,
    input  logic               auto_clr,
    output logic [NUM_SRC-1:0] ack_clr,
    output logic [DATA_W-1:0]  vector
);
    ack_state_t state, state_nx;
    logic       accept;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ACK_WAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        unique case (state)
            ACK_WAIT: if (ack) begin
                accept   = 1'b1;
                state_nx = ACK_HOLD;
            end
            ACK_HOLD: if (!ack) state_nx = ACK_WAIT;
        endcase
    end

    always_comb begin
        ack_clr = '0;
        if (accept) ack_clr = grant & {1'b1, {NUM_DMA{auto_clr}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      vector <= '0;
        else if (accept) vector <= {vbase_hi, code, 1'b0};
    end

    // R7: base bits and zero bit 0
    a_r7_vec_fields: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (vector[0] == 1'b0) && (vector[DATA_W-1 -: BASE_W] == $past(vbase_hi)));
    // R6: raster wins when pending
    a_r6_raster_first: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pend[RASTER_IX]) |=> (vector[2:1] == CODE_RASTER));
    // R10: empty acknowledge uses raster code
    a_r10_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pend == '0) |=> (vector[2:1] == CODE_RASTER));
    // R11: vector holds while the strobe lasts
    a_r11_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACK_HOLD) |=> $stable(vector));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               raster_req,
    input  logic [NUM_DMA-1:0] dma_req,
    input  logic [NUM_DMA-1:0] dma_stop,
    input  logic               ack,
    output logic [DATA_W-1:0]  vector,
    output logic               irq_n,
    output logic [NUM_DMA-1:0] dma_en
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] ack_clr;
    logic [NUM_DMA-1:0] cpu_clr;
    logic [CODE_W-1:0]  code;
    logic [BASE_W-1:0]  vbase_hi;
    logic               auto_clr;

    irqv_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dma_stop(dma_stop), .pend(pend),
        .en(dma_en), .cpu_clr(cpu_clr), .vbase_hi(vbase_hi),
        .auto_clr(auto_clr), .reg_rdata(reg_rdata)
    );

    irqv_flags u_flags (
        .clk(clk), .rst_n(rst_n), .raster_set(raster_req), .dma_set(dma_req),
        .cpu_clr(cpu_clr), .ack_clr(ack_clr), .pend(pend)
    );

    irqv_prio u_prio (.pend(pend), .grant(grant), .code(code));

    irqv_ack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ack(ack), .pend(pend), .grant(grant),
        .code(code), .vbase_hi(vbase_hi), .auto_clr(auto_clr),
        .ack_clr(ack_clr), .vector(vector)
    );

    assign irq_n = ~|pend;

    // R4: a raster request drives the line low next cycle
    a_r4_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        raster_req |=> !irq_n);
    // R5: a CPU write never retires the raster flag
    a_r5_raster_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[RASTER_IX] && reg_wr && !reg_sel && !ack) |=> !irq_n);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       raster_req = 1'b0;
    logic [2:0] dma_req = '0;
    logic [2:0] dma_stop = '0;
    logic       ack = 1'b0;
    logic [7:0] vector;
    logic       irq_n;
    logic [2:0] dma_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    logic ack_prev = 1'b0;
    logic acc_evt = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raster_req(raster_req),
        .dma_req(dma_req), .dma_stop(dma_stop), .ack(ack), .vector(vector),
        .irq_n(irq_n), .dma_en(dma_en)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic sel, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse(input logic r, input logic [2:0] d);
        raster_req = r; dma_req = d;
        step();
        raster_req = 1'b0; dma_req = '0;
    endtask

    task automatic ack_cycle(input logic [7:0] exp);
        exp_q.push_back(exp);
        ack = 1'b1;
        step();
        ack = 1'b0;
        step();
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        ack_prev <= ack;
        acc_evt  <= ack && !ack_prev;
    end

    always @(negedge clk) begin
        if (acc_evt && rst_n) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 unexpected acknowledge actual=%h expected=none", vector);
            end else begin
                check("R6/R7 vector", vector, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        rd("R1 csr", 1'b0, 8'hF0);
        rd("R1 vbase", 1'b1, 8'h01);
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        // R2
        wr(1'b0, 8'h05); rd("R2 enables set", 1'b0, 8'hF5);
        wr(1'b0, 8'h02); rd("R2 enables clear", 1'b0, 8'hF2);
        check("R2 dma_en", {5'b0, dma_en}, 8'h02);
        // R3
        dma_stop = 3'b010; step(); dma_stop = '0;
        rd("R3 stop clears", 1'b0, 8'hF0);
        dma_stop = 3'b001; wr(1'b0, 8'h07); dma_stop = '0;
        rd("R3 stop beats write", 1'b0, 8'hF6);
        // R4
        pulse(1'b1, 3'b000);
        check("R4 irq_n low", {7'b0, irq_n}, 8'h00);
        rd("R4 raster flag", 1'b0, 8'h76);
        // R5 bit7 write ignored
        wr(1'b0, 8'h86); rd("R5 raster kept", 1'b0, 8'h76);
        // R7 vbase
        wr(1'b1, 8'hAF); rd("R7 vbase unused bits", 1'b1, 8'hA9);
        // R6 R8 R9 auto on
        pulse(1'b0, 3'b101);
        rd("R4 dma flags", 1'b0, 8'h26);
        ack_cycle(8'hAE);
        rd("R8 raster cleared", 1'b0, 8'hA6);
        ack_cycle(8'hA8);
        ack_cycle(8'hAC);
        rd("R9 dma auto cleared", 1'b0, 8'hF6);
        check("R4 irq_n high", {7'b0, irq_n}, 8'h01);
        // R9 auto off, R5 clears
        wr(1'b1, 8'hA8);
        pulse(1'b0, 3'b010);
        ack_cycle(8'hAA);
        rd("R9 flag kept", 1'b0, 8'hD6);
        ack_cycle(8'hAA);
        wr(1'b0, 8'h06); rd("R5 zero no effect", 1'b0, 8'hD6);
        wr(1'b0, 8'h26); rd("R5 cpu clear", 1'b0, 8'hF6);
        check("R5 irq_n high", {7'b0, irq_n}, 8'h01);
        // R10 empty acknowledge
        ack_cycle(8'hAE);
        rd("R10 no change", 1'b0, 8'hF6);
        check("R10 irq_n", {7'b0, irq_n}, 8'h01);
        // R11 held strobe
        wr(1'b1, 8'hA9);
        pulse(1'b0, 3'b011);
        exp_q.push_back(8'hAA);
        ack = 1'b1;
        step();
        pulse(1'b1, 3'b000);
        step();
        check("R11 vector stable", vector, 8'hAA);
        ack = 1'b0;
        step();
        rd("R11 one retired", 1'b0, 8'h66);
        ack_cycle(8'hAE);
        ack_cycle(8'hAC);
        rd("R11 drained", 1'b0, 8'hF6);
        // R12 request vs clear
        pulse(1'b0, 3'b100);
        dma_req = 3'b100; wr(1'b0, 8'h46); dma_req = '0;
        rd("R12 request wins", 1'b0, 8'hB6);
        wr(1'b0, 8'h46); rd("R12 later clear", 1'b0, 8'hF6);
        step();
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R11 missing vectors actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule